// File: doc/BRIEF.md
# SPI Serial-Memory Command Front End

This block is the slave-side front end of a serial memory reached over SPI in mode 0. It watches the chip-select, serial clock and data-in lines through synchronisers running on the system clock. It frames each transaction between a falling and a rising chip select and collects bits most significant first. The first byte of every transaction is taken as an 8-bit command code. From that code the block looks up how many address bytes follow and how many data bytes the command carries: none, a fixed count, or a stream that runs until deselection.

In the data phase, a command that writes raises a one-cycle write strobe for each received byte, with the byte and its address. A command that reads raises a one-cycle fetch request. It takes the returned byte in that same cycle and shifts it out on the serial output, most significant first, one bit after each falling serial-clock edge. The address advances after every data byte.

The block also keeps the write-enable latch. Two dedicated commands set and clear it, and any completed write-type command clears it. The memory itself, integrity checking, nonvolatile copy and power handling lie behind the byte interface and are not part of the block.

Top module: `spi_mem_frontend`

## Requirements
- R1: After reset `wel`, `spi_miso_oe`, `be_wr_stb` and `be_rd_req` are all 0.
- R2: The first byte after chip select falls is taken as the command, most significant bit first, and appears on `be_cmd` once it is complete.
- R3: Code 06h sets and code 04h clears `wel` when chip select rises after exactly 8 serial-clock rises.
- R4: If code 06h or 04h is followed by any further serial-clock rise before deselection, `wel` keeps its value.
- R5: Code 02h takes 2 address bytes, most significant byte first, then issues one `be_wr_stb` per received data byte, with `be_addr` starting at the given address and incrementing by one per byte, for as long as bytes arrive.
- R6: Code 03h takes 2 address bytes and then streams reads. `be_rd_req` pulses on entry to the data phase and at the end of every data byte, with `be_addr` incrementing by one each time. `be_rdata` is taken in the request cycle. Each byte is driven on `spi_miso`, most significant bit first, changing after falling serial-clock edges, with `spi_miso_oe` high.
- R7: The read codes with no address start at `be_addr` 0. Code 0Ah returns exactly 2 bytes, 05h exactly 1 and C3h exactly 2. After that, `spi_miso_oe` stays 0 until deselection.
- R8: The write codes with no address start at `be_addr` 0. Code 01h accepts exactly 1 byte and C2h exactly 2. Further bytes raise no strobe.
- R9: Codes 12h and 13h take 2 address bytes and then exactly SEC_LEN data bytes. Further bytes give no strobe, no request and no output enable.
- R10: When chip select rises after a completed write-type command, `wel` is cleared. Code 02h is complete after at least one data byte; 12h, 01h and C2h are complete after their full count. An incomplete fixed-count write leaves `wel` unchanged.
- R11: An unknown code, and the codes 08h, 09h and B9h, produce no strobe and no request, never raise `spi_miso_oe`, and leave `wel` unchanged.
- R12: A chip-select rise at any point abandons the transaction. The next selection starts again with a fresh command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out, 0 when not enabled |
| spi_miso_oe | output | 1 | Output enable for the serial data out |
| be_cmd | output | 8 | Command code of the current transaction |
| be_addr | output | 8*ADDR_BYTES | Byte address that goes with a strobe or request |
| be_wr_stb | output | 1 | One-cycle strobe: received byte on be_wdata |
| be_wdata | output | 8 | Received data byte |
| be_rd_req | output | 1 | One-cycle fetch request for be_addr |
| be_rdata | input | 8 | Fetched byte, valid in the request cycle |
| wel | output | 1 | Write-enable latch |

## Verification
The bench builds the block with ADDR_BYTES at 2 and SEC_LEN reduced to 4. With the shorter count, the end of a secure transfer, the byte after it, and a transfer cut short before its count are all reached within a few dozen serial bytes. With two address bytes, a read that starts at 12FEh crosses from one low byte to the next, so the carry of the address increment is exercised. The synchroniser depth stays at 2, and each serial-clock half-period lasts 8 system cycles, so the output bit and the next fetch are both settled before the master samples.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam logic [7:0] OP_WEL_SET  = 8'h06;
    localparam logic [7:0] OP_WEL_CLR  = 8'h04;
    localparam logic [7:0] OP_ARR_WR   = 8'h02;
    localparam logic [7:0] OP_ARR_RD   = 8'h03;
    localparam logic [7:0] OP_LAST_ADR = 8'h0A;
    localparam logic [7:0] OP_SEC_WR   = 8'h12;
    localparam logic [7:0] OP_SEC_RD   = 8'h13;
    localparam logic [7:0] OP_STAT_WR  = 8'h01;
    localparam logic [7:0] OP_STAT_RD  = 8'h05;
    localparam logic [7:0] OP_SAVE     = 8'h08;
    localparam logic [7:0] OP_RESTORE  = 8'h09;
    localparam logic [7:0] OP_SLEEP    = 8'hB9;
    localparam logic [7:0] OP_USR_WR   = 8'hC2;
    localparam logic [7:0] OP_USR_RD   = 8'hC3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_TAIL,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic        known;
        logic        is_rd;
        logic        is_wr;
        logic        has_addr;
        logic        stream;
        logic        is_wel;
        logic [15:0] count;
    } cmd_prof_t;

endpackage

// File: rtl/spim_sync.sv
module spim_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= stg_q[STAGES-1];
    end

    assign dout = stg_q[STAGES-1];
    assign rise = stg_q[STAGES-1] & ~prev_q;
    assign fall = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/spim_decode.sv
module spim_decode
    import spim_pkg::*;
#(
    parameter int SEC_LEN = 32
) (
    input  logic [7:0] opc,
    output cmd_prof_t  prof
);
    localparam logic [15:0] SEC_CNT = 16'(SEC_LEN);

    always_comb begin
        prof = '0;
        prof.known = 1'b1;
        case (opc)
            OP_WEL_SET, OP_WEL_CLR: prof.is_wel = 1'b1;
            OP_ARR_WR: begin
                prof.is_wr    = 1'b1;
                prof.has_addr = 1'b1;
                prof.stream   = 1'b1;
            end
            OP_ARR_RD: begin
                prof.is_rd    = 1'b1;
                prof.has_addr = 1'b1;
                prof.stream   = 1'b1;
            end
            OP_SEC_WR: begin
                prof.is_wr    = 1'b1;
                prof.has_addr = 1'b1;
                prof.count    = SEC_CNT;
            end
            OP_SEC_RD: begin
                prof.is_rd    = 1'b1;
                prof.has_addr = 1'b1;
                prof.count    = SEC_CNT;
            end
            OP_LAST_ADR, OP_USR_RD: begin
                prof.is_rd = 1'b1;
                prof.count = 16'd2;
            end
            OP_USR_WR: begin
                prof.is_wr = 1'b1;
                prof.count = 16'd2;
            end
            OP_STAT_RD: begin
                prof.is_rd = 1'b1;
                prof.count = 16'd1;
            end
            OP_STAT_WR: begin
                prof.is_wr = 1'b1;
                prof.count = 16'd1;
            end
            OP_SAVE, OP_RESTORE, OP_SLEEP: ;
            default: prof.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/spim_core.sv
module spim_core
    import spim_pkg::*;
#(
    parameter int ADDR_BYTES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs_n_s,
    input  logic                    cs_rise,
    input  logic                    cs_fall,
    input  logic                    sck_rise,
    input  logic                    sck_fall,
    input  logic                    mosi_s,
    output logic [7:0]              opc_cand,
    input  cmd_prof_t               prof_in,
    output logic                    miso,
    output logic                    miso_oe,
    output logic [7:0]              cmd,
    output logic [8*ADDR_BYTES-1:0] be_addr,
    output logic                    wr_stb,
    output logic [7:0]              wdata,
    output logic                    rd_req,
    input  logic [7:0]              rdata,
    output logic                    wel
);
    localparam int AW  = 8 * ADDR_BYTES;
    localparam int ACW = $clog2(ADDR_BYTES + 1);
    localparam logic [ACW-1:0] ALAST = ACW'(ADDR_BYTES - 1);

    typedef struct packed {
        phase_e    phase;
        logic [2:0] bitcnt;
        logic [7:0] sh;
        logic [7:0] opc;
        cmd_prof_t prof;
        logic [AW-1:0] addr;
        logic [ACW-1:0] abyte;
        logic [15:0] dcnt;
        logic      wr_done;
        logic      wel;
        logic      wel_pend;
        logic [7:0] tx;
        logic      miso;
        logic      oe;
        logic      wr_stb;
        logic      rd_req;
        logic [AW-1:0] be_addr;
        logic [7:0] wdata;
    } st_t;

    st_t st_d, st_q;
    logic [7:0]    nb;
    logic [AW+7:0] addr_cat;

    assign nb       = {st_q.sh[6:0], mosi_s};
    assign opc_cand = nb;
    assign addr_cat = {st_q.addr, nb};

    always_comb begin
        st_d        = st_q;
        st_d.wr_stb = 1'b0;
        st_d.rd_req = 1'b0;
        if (st_q.rd_req) st_d.tx = rdata;

        if (cs_rise) begin
            if (st_q.phase == PH_TAIL && st_q.wel_pend)
                st_d.wel = (st_q.opc == OP_WEL_SET);
            else if (st_q.wr_done)
                st_d.wel = 1'b0;
            st_d.phase    = PH_IDLE;
            st_d.oe       = 1'b0;
            st_d.wel_pend = 1'b0;
            st_d.wr_done  = 1'b0;
        end else if (cs_fall) begin
            st_d.phase    = PH_OPC;
            st_d.bitcnt   = '0;
            st_d.addr     = '0;
            st_d.abyte    = '0;
            st_d.dcnt     = '0;
            st_d.wr_done  = 1'b0;
            st_d.wel_pend = 1'b0;
            st_d.oe       = 1'b0;
        end else if (!cs_n_s && st_q.phase != PH_IDLE) begin
            if (sck_rise) begin
                st_d.sh     = nb;
                st_d.bitcnt = st_q.bitcnt + 3'd1;
                if (st_q.phase == PH_TAIL) st_d.wel_pend = 1'b0;
                if (st_q.bitcnt == 3'd7) begin
                    case (st_q.phase)
                        PH_OPC: begin
                            st_d.opc  = nb;
                            st_d.prof = prof_in;
                            if (!prof_in.known) begin
                                st_d.phase = PH_SKIP;
                            end else if (prof_in.has_addr) begin
                                st_d.phase = PH_ADDR;
                            end else if (prof_in.stream || prof_in.count != 16'd0) begin
                                st_d.phase = PH_DATA;
                                if (prof_in.is_rd) begin
                                    st_d.rd_req  = 1'b1;
                                    st_d.be_addr = st_q.addr;
                                    st_d.addr    = st_q.addr + AW'(1);
                                    st_d.dcnt    = 16'd1;
                                end
                            end else begin
                                st_d.phase    = PH_TAIL;
                                st_d.wel_pend = prof_in.is_wel;
                            end
                        end
                        PH_ADDR: begin
                            st_d.addr  = addr_cat[AW-1:0];
                            st_d.abyte = st_q.abyte + ACW'(1);
                            if (st_q.abyte == ALAST) begin
                                st_d.phase = PH_DATA;
                                if (st_q.prof.is_rd) begin
                                    st_d.rd_req  = 1'b1;
                                    st_d.be_addr = addr_cat[AW-1:0];
                                    st_d.addr    = addr_cat[AW-1:0] + AW'(1);
                                    st_d.dcnt    = 16'd1;
                                end
                            end
                        end
                        PH_DATA: begin
                            if (st_q.prof.is_wr) begin
                                st_d.wr_stb  = 1'b1;
                                st_d.be_addr = st_q.addr;
                                st_d.wdata   = nb;
                                st_d.addr    = st_q.addr + AW'(1);
                                st_d.dcnt    = st_q.dcnt + 16'd1;
                                if (st_q.prof.stream) begin
                                    st_d.wr_done = 1'b1;
                                end else if (st_q.dcnt + 16'd1 == st_q.prof.count) begin
                                    st_d.wr_done = 1'b1;
                                    st_d.phase   = PH_TAIL;
                                end
                            end else if (st_q.prof.stream || st_q.dcnt < st_q.prof.count) begin
                                st_d.rd_req  = 1'b1;
                                st_d.be_addr = st_q.addr;
                                st_d.addr    = st_q.addr + AW'(1);
                                st_d.dcnt    = st_q.dcnt + 16'd1;
                            end else begin
                                st_d.phase = PH_TAIL;
                                st_d.oe    = 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end else if (sck_fall) begin
                if (st_q.phase == PH_DATA && st_q.prof.is_rd) begin
                    st_d.oe   = 1'b1;
                    st_d.miso = st_q.tx[3'd7 - st_q.bitcnt];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign miso    = st_q.oe & st_q.miso;
    assign miso_oe = st_q.oe;
    assign cmd     = st_q.opc;
    assign be_addr = st_q.be_addr;
    assign wr_stb  = st_q.wr_stb;
    assign wdata   = st_q.wdata;
    assign rd_req  = st_q.rd_req;
    assign wel     = st_q.wel;
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
    import spim_pkg::*;
#(
    parameter int ADDR_BYTES  = 2,
    parameter int SEC_LEN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    output logic                    spi_miso_oe,
    output logic [7:0]              be_cmd,
    output logic [8*ADDR_BYTES-1:0] be_addr,
    output logic                    be_wr_stb,
    output logic [7:0]              be_wdata,
    output logic                    be_rd_req,
    input  logic [7:0]              be_rdata,
    output logic                    wel
);
    logic [2:0] sync_lvl, sync_rise, sync_fall;
    logic [7:0] opc_cand;
    cmd_prof_t  prof;

    spim_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_sck, spi_cs_n, spi_mosi}),
        .dout  (sync_lvl),
        .rise  (sync_rise),
        .fall  (sync_fall)
    );

    spim_decode #(
        .SEC_LEN (SEC_LEN)
    ) dec_i (
        .opc  (opc_cand),
        .prof (prof)
    );

    spim_core #(
        .ADDR_BYTES (ADDR_BYTES)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (sync_lvl[1]),
        .cs_rise  (sync_rise[1]),
        .cs_fall  (sync_fall[1]),
        .sck_rise (sync_rise[2]),
        .sck_fall (sync_fall[2]),
        .mosi_s   (sync_lvl[0]),
        .opc_cand (opc_cand),
        .prof_in  (prof),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe),
        .cmd      (be_cmd),
        .be_addr  (be_addr),
        .wr_stb   (be_wr_stb),
        .wdata    (be_wdata),
        .rd_req   (be_rd_req),
        .rdata    (be_rdata),
        .wel      (wel)
    );
endmodule

// File: rtl/spi_mem_frontend_chk.sv
module spi_mem_frontend_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_miso_oe,
    input logic [7:0] be_cmd,
    input logic       be_wr_stb,
    input logic       be_rd_req,
    input logic       wel
);
    logic cmd_rd, cmd_wr;
    assign cmd_rd = (be_cmd == 8'h03) || (be_cmd == 8'h13) || (be_cmd == 8'h0A) ||
                    (be_cmd == 8'h05) || (be_cmd == 8'hC3);
    assign cmd_wr = (be_cmd == 8'h02) || (be_cmd == 8'h12) || (be_cmd == 8'h01) ||
                    (be_cmd == 8'hC2);

    AST_STB_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(be_wr_stb && be_rd_req)); // R5
    AST_WR_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) be_wr_stb |=> !be_wr_stb); // R5
    AST_RD_PULSE:   assert property (@(posedge clk) disable iff (!rst_n) be_rd_req |=> !be_rd_req); // R6
    AST_RD_CMD:     assert property (@(posedge clk) disable iff (!rst_n) be_rd_req |-> cmd_rd); // R7
    AST_WR_CMD:     assert property (@(posedge clk) disable iff (!rst_n) be_wr_stb |-> cmd_wr); // R8
    AST_OE_CMD:     assert property (@(posedge clk) disable iff (!rst_n) spi_miso_oe |-> cmd_rd); // R11
    AST_WEL_DESEL:  assert property (@(posedge clk) disable iff (!rst_n) !$stable(wel) |-> spi_cs_n); // R3
endmodule

bind spi_mem_frontend spi_mem_frontend_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n    (spi_cs_n),
    .spi_miso_oe (spi_miso_oe),
    .be_cmd      (be_cmd),
    .be_wr_stb   (be_wr_stb),
    .be_rd_req   (be_rd_req),
    .wel         (wel)
);

// File: tb/spi_mem_frontend_tb_top.sv
module spi_mem_frontend_tb_top;
    localparam int AB  = 2;
    localparam int SEC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe;
    logic [7:0]  be_cmd, be_wdata, be_rdata;
    logic [15:0] be_addr;
    logic        be_wr_stb, be_rd_req, wel;

    int tests = 0;
    int fails = 0;
    logic oe_seen = 1'b0;

    logic [23:0] exp_wr_q[$];
    logic [15:0] exp_rd_q[$];

    always #2 clk = ~clk;

    spi_mem_frontend #(.ADDR_BYTES(AB), .SEC_LEN(SEC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .be_cmd(be_cmd), .be_addr(be_addr), .be_wr_stb(be_wr_stb),
        .be_wdata(be_wdata), .be_rd_req(be_rd_req), .be_rdata(be_rdata), .wel(wel)
    );

    function automatic logic [7:0] mem_model(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    assign be_rdata = mem_model(be_addr);

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_miso_oe) oe_seen = 1'b1;
            if (be_wr_stb) begin
                if (exp_wr_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected write strobe", {8'h0, be_addr, be_wdata}, 32'h0);
                end else begin
                    logic [23:0] e;
                    e = exp_wr_q.pop_front();
                    chk({be_addr, be_wdata} == e, "R5 write addr/data", {8'h0, be_addr, be_wdata},
                        {8'h0, e});
                end
            end
            if (be_rd_req) begin
                if (exp_rd_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected read request", {16'h0, be_addr}, 32'h0);
                end else begin
                    logic [15:0] e;
                    e = exp_rd_q.pop_front();
                    chk(be_addr == e, "R6 read addr", {16'h0, be_addr}, {16'h0, e});
                end
            end
        end
    end

    task automatic sel();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic desel();
        repeat (8) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx,
                         output logic oe_any);
        rx = '0;
        oe_any = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            spi_mosi = tx[i];
            repeat (8) @(negedge clk);
            rx[i] = spi_miso;
            if (spi_miso_oe) oe_any = 1'b1;
            spi_sck = 1'b1;
            repeat (8) @(negedge clk);
            spi_sck = 1'b0;
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
        xbits(tx, 8, rx, oe_any);
    endtask

    task automatic sb_drained(input string req);
        chk(exp_wr_q.size() == 0 && exp_rd_q.size() == 0, req,
            exp_wr_q.size() + exp_rd_q.size(), 0);
    endtask

    task automatic simple_cmd(input logic [7:0] op);
        logic [7:0] rx;
        logic oe;
        sel();
        xbyte(op, rx, oe);
        desel();
    endtask

    task automatic read_bytes(input logic [15:0] a0, input int n, input string req);
        logic [7:0] rx;
        logic oe;
        for (int k = 0; k < n; k++) begin
            xbyte(8'h00, rx, oe);
            chk(rx == mem_model(a0 + 16'(k)), req, rx, mem_model(a0 + 16'(k)));
            chk(oe, req, oe, 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        logic oe;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(wel == 0 && spi_miso_oe == 0 && be_wr_stb == 0 && be_rd_req == 0, "R1 reset",
            {wel, spi_miso_oe, be_wr_stb, be_rd_req}, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 / R3
        simple_cmd(8'h06);
        chk(be_cmd == 8'h06, "R2 command byte", be_cmd, 8'h06);
        chk(wel == 1, "R3 set", wel, 1);
        simple_cmd(8'h04);
        chk(wel == 0, "R3 clear", wel, 0);
        simple_cmd(8'h06);
        chk(wel == 1, "R3 set again", wel, 1);

        // R4 extra bit after clear code
        sel(); xbyte(8'h04, rx, oe); xbits(8'h80, 1, rx, oe); desel();
        chk(wel == 1, "R4 extra bit", wel, 1);

        // R5 / R10 streaming write
        exp_wr_q.push_back({16'h1234, 8'hAA});
        exp_wr_q.push_back({16'h1235, 8'hBB});
        exp_wr_q.push_back({16'h1236, 8'hCC});
        sel();
        xbyte(8'h02, rx, oe); xbyte(8'h12, rx, oe); xbyte(8'h34, rx, oe);
        xbyte(8'hAA, rx, oe); xbyte(8'hBB, rx, oe); xbyte(8'hCC, rx, oe);
        desel();
        sb_drained("R5 writes");
        chk(wel == 0, "R10 cleared after write", wel, 0);

        // R6 streaming read across low-byte carry
        for (int k = 0; k < 4; k++) exp_rd_q.push_back(16'h12FE + 16'(k));
        sel();
        xbyte(8'h03, rx, oe); xbyte(8'h12, rx, oe); xbyte(8'hFE, rx, oe);
        read_bytes(16'h12FE, 3, "R6 read data");
        desel();
        sb_drained("R6 requests");

        // R7 no-address reads
        exp_rd_q.push_back(16'h0000);
        exp_rd_q.push_back(16'h0001);
        sel();
        xbyte(8'h0A, rx, oe);
        read_bytes(16'h0000, 2, "R7 last-address data");
        xbyte(8'h00, rx, oe);
        chk(oe == 0, "R7 no output after count", oe, 0);
        desel();
        sb_drained("R7 requests");
        exp_rd_q.push_back(16'h0000);
        sel();
        xbyte(8'h05, rx, oe);
        read_bytes(16'h0000, 1, "R7 status data");
        xbyte(8'h00, rx, oe);
        chk(oe == 0, "R7 status single byte", oe, 0);
        desel();
        sb_drained("R7 status request");

        // R8 no-address writes, R10 clear
        simple_cmd(8'h06);
        exp_wr_q.push_back({16'h0000, 8'h11});
        exp_wr_q.push_back({16'h0001, 8'h22});
        sel();
        xbyte(8'hC2, rx, oe); xbyte(8'h11, rx, oe); xbyte(8'h22, rx, oe); xbyte(8'h33, rx, oe);
        desel();
        sb_drained("R8 user writes");
        chk(wel == 0, "R10 cleared after user write", wel, 0);
        simple_cmd(8'h06);
        exp_wr_q.push_back({16'h0000, 8'h5A});
        sel();
        xbyte(8'h01, rx, oe); xbyte(8'h5A, rx, oe); xbyte(8'h77, rx, oe);
        desel();
        sb_drained("R8 status write");
        chk(wel == 0, "R10 cleared after status write", wel, 0);

        // R9 secure write / read
        simple_cmd(8'h06);
        for (int k = 0; k < SEC; k++) exp_wr_q.push_back({16'h2000 + 16'(k), 8'(8'h40 + k)});
        sel();
        xbyte(8'h12, rx, oe); xbyte(8'h20, rx, oe); xbyte(8'h00, rx, oe);
        for (int k = 0; k <= SEC; k++) xbyte(8'(8'h40 + k), rx, oe);
        desel();
        sb_drained("R9 secure writes");
        chk(wel == 0, "R10 cleared after secure write", wel, 0);
        for (int k = 0; k < SEC; k++) exp_rd_q.push_back(16'h3000 + 16'(k));
        sel();
        xbyte(8'h13, rx, oe); xbyte(8'h30, rx, oe); xbyte(8'h00, rx, oe);
        read_bytes(16'h3000, SEC, "R9 secure read data");
        xbyte(8'h00, rx, oe);
        chk(oe == 0, "R9 no output past count", oe, 0);
        desel();
        sb_drained("R9 secure requests");

        // R10 incomplete fixed-count write
        simple_cmd(8'h06);
        exp_wr_q.push_back({16'h2000, 8'h01});
        exp_wr_q.push_back({16'h2001, 8'h02});
        sel();
        xbyte(8'h12, rx, oe); xbyte(8'h20, rx, oe); xbyte(8'h00, rx, oe);
        xbyte(8'h01, rx, oe); xbyte(8'h02, rx, oe);
        desel();
        sb_drained("R10 partial writes");
        chk(wel == 1, "R10 incomplete keeps latch", wel, 1);

        // R11 unknown and no-payload codes
        oe_seen = 1'b0;
        sel();
        xbyte(8'hFF, rx, oe); xbyte(8'h12, rx, oe); xbyte(8'h34, rx, oe); xbyte(8'h56, rx, oe);
        desel();
        simple_cmd(8'h08);
        simple_cmd(8'h09);
        simple_cmd(8'hB9);
        chk(oe_seen == 0, "R11 output never enabled", oe_seen, 0);
        chk(wel == 1, "R11 latch unchanged", wel, 1);

        // R12 aborts
        sel(); xbyte(8'h03, rx, oe); xbyte(8'h12, rx, oe); desel();
        sb_drained("R12 aborted read issues nothing");
        sel(); xbits(8'h00, 4, rx, oe); desel();
        simple_cmd(8'h04);
        chk(wel == 0, "R12 fresh command after abort", wel, 0);
        chk(be_cmd == 8'h04, "R12 command realigned", be_cmd, 8'h04);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule